// File: doc/BRIEF.md
# Sensor Sample Frame FIFO with Reconfiguration Flush

This block buffers measurement frames from a pressure/temperature sensor until the host collects them. It runs in one of two layouts. In the first, every frame carries both a pressure word and a temperature word. In the second, every frame carries one channel word. Storage is a pool of single-channel slots. A combined frame takes two adjacent slots, so the pool holds half as many combined frames as single-channel ones.

Stored data is only meaningful under the measurement setup that produced it, so the block watches its configuration inputs. It empties itself whenever the sensor setup changes. It also empties itself when a new frame layout or a new decimation choice is applied. While it empties, it raises a busy output for a fixed number of cycles, and a longer number applies when the device sits in deep standby.

Frame-layout and decimation changes are applied only in standby. A change written in any other mode waits until standby is entered. A frame-select change that waits still empties the FIFO when it is applied. A decimation change that waits does not.

Top module: `sensor_frame_fifo`

## Requirements
- R1: Reset leaves frameCount at 0, fullFlag, thrFlag and flushBusy low, rdData at 0 and decSelAct at 0.
- R2: When frameSelCfg is 2'b01 or 2'b10, the block is in single-channel layout. Each accepted write stores wrData[CH_W-1:0]. A read returns the frames in write order, with the upper CH_W bits of rdData set to zero. Capacity is SLOTS frames, and fullFlag is high exactly when the FIFO holds that many.
- R3: When frameSelCfg is 2'b11, the block is in combined layout. A write stores the whole wrData, pressure in the upper half and temperature in the lower half, and a read returns the whole word. Capacity is SLOTS/2 frames.
- R4: A write while fullFlag is high is dropped. A read with frameCount at 0 sets rdData to 0 and changes nothing else. Read data appears on rdData one cycle after rdEn.
- R5: thrFlag is high when thrLvl is non-zero and frameCount is at least thrLvl. It follows a new thrLvl with no clock edge in between. A thrLvl of 0 keeps it low.
- R6: A change to osrTCfg, osrPCfg, odrCfg or pwrCfg flushes the FIFO at the next edge. The flush sets frameCount to 0, which clears fullFlag and thrFlag. flushBusy is then high for FLUSH_CYC cycles.
- R7: If curMode is 3'd4 (deep standby) when a flush starts, flushBusy stays high for FLUSH_DEEP_CYC cycles.
- R8: While flushBusy is high, and in the cycle in which a flush starts, writes are dropped and reads return 0.
- R9: curMode 3'd0 and 3'd4 count as standby. A frameSelCfg change seen in standby is applied at once and flushes. A change made in any other mode keeps the old layout and does not flush until standby is entered. At that point it is applied and flushes.
- R10: A decSelCfg change seen in standby updates decSelAct and flushes. A change made outside standby leaves decSelAct unchanged until standby is entered. It then updates decSelAct without a flush.
- R11: With frameSelCfg at 2'b00, every write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Frame write strobe |
| wrData | input | 2*CH_W | Frame data: pressure upper half, temperature lower half |
| rdEn | input | 1 | Frame read strobe |
| rdData | output | 2*CH_W | Frame read one cycle after rdEn |
| osrTCfg | input | 3 | Temperature oversampling setting |
| osrPCfg | input | 3 | Pressure oversampling setting |
| odrCfg | input | 5 | Output data rate setting |
| pwrCfg | input | 2 | Requested power mode setting |
| frameSelCfg | input | 2 | Frame layout: bit1 pressure, bit0 temperature |
| decSelCfg | input | 2 | Decimation selection |
| curMode | input | 3 | Present power mode: 0 standby, 1 normal, 2 forced, 3 continuous, 4 deep standby |
| thrLvl | input | CNT_W | Frame threshold level |
| frameCount | output | CNT_W | Frames held |
| fullFlag | output | 1 | FIFO at capacity |
| thrFlag | output | 1 | Fill level at or above threshold |
| flushBusy | output | 1 | Flush in progress |
| decSelAct | output | 2 | Decimation selection in force |

## Verification
The bench uses 32 slots of 24 bits, a 4-cycle normal flush and a 9-cycle deep flush. These short flush times let it count the busy window cycle by cycle in both cases, and still have spare cycles inside the window to try writes and reads. With 32 slots, both the 32-frame single-channel limit and the 16-frame combined limit can be reached in a few hundred cycles. Overflow, underflow and the deferred-layout paths each get their own scenario.

// File: rtl/sff_pkg.sv
package sff_pkg;

  typedef enum logic [2:0] {
    MODE_STANDBY    = 3'd0,
    MODE_NORMAL     = 3'd1,
    MODE_FORCED     = 3'd2,
    MODE_CONTINUOUS = 3'd3,
    MODE_DEEP       = 3'd4
  } pwrMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clr;    // flush: empty storage
    logic push;   // accept a frame
    logic pop;    // deliver a frame
    logic rdReq;  // host asked for a frame
    logic pair;   // combined layout in force
  } sffStrobe_t;

endpackage

// File: rtl/sff_store.sv
module sff_store
  import sff_pkg::*;
#(
  parameter int SLOTS = 32,
  parameter int CH_W  = 24,
  localparam int PTR_W = $clog2(SLOTS),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  sffStrobe_t        stb,
  input  logic [2*CH_W-1:0] wrData,
  output logic [2*CH_W-1:0] rdData,
  output logic [CNT_W-1:0]  frameCount,
  output logic              isFull,
  output logic              isEmpty
);

  logic [CH_W-1:0]  slotMem [SLOTS];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] fillSlots;
  logic [CNT_W-1:0] step;
  logic [PTR_W-1:0] wrPtrNext, rdPtrNext;

  assign step      = stb.pair ? CNT_W'(2) : CNT_W'(1);
  assign wrPtrNext = wrPtr + PTR_W'(1);
  assign rdPtrNext = rdPtr + PTR_W'(1);

  assign isFull     = (fillSlots == CNT_W'(SLOTS));
  assign isEmpty    = (fillSlots == '0);
  assign frameCount = stb.pair ? (fillSlots >> 1) : fillSlots;

  always_ff @(posedge clk) begin
    if (stb.push) begin
      slotMem[wrPtr] <= wrData[CH_W-1:0];
      if (stb.pair) slotMem[wrPtrNext] <= wrData[2*CH_W-1:CH_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillSlots <= '0;
      rdData    <= '0;
    end else if (stb.clr) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillSlots <= '0;
      if (stb.rdReq) rdData <= '0;
    end else begin
      if (stb.push) wrPtr <= wrPtr + PTR_W'(step);
      if (stb.pop)  rdPtr <= rdPtr + PTR_W'(step);
      fillSlots <= fillSlots + (stb.push ? step : '0) - (stb.pop ? step : '0);
      if (stb.pop) begin
        if (stb.pair) rdData <= {slotMem[rdPtrNext], slotMem[rdPtr]};
        else          rdData <= {{CH_W{1'b0}}, slotMem[rdPtr]};
      end else if (stb.rdReq) begin
        rdData <= '0;
      end
    end
  end

endmodule

// File: rtl/sff_ctrl.sv
module sff_ctrl
  import sff_pkg::*;
#(
  parameter int FLUSH_CYC      = 4,
  parameter int FLUSH_DEEP_CYC = 9,
  localparam int FC_W = $clog2(FLUSH_DEEP_CYC + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [2:0] osrTCfg,
  input  logic [2:0] osrPCfg,
  input  logic [4:0] odrCfg,
  input  logic [1:0] pwrCfg,
  input  logic [1:0] frameSelCfg,
  input  logic [1:0] decSelCfg,
  input  logic [2:0] curMode,
  input  logic       isFull,
  input  logic       isEmpty,
  output sffStrobe_t stb,
  output logic       flushBusy,
  output logic [1:0] decSelAct
);

  logic            primed;
  logic [2:0]      osrTSh, osrPSh;
  logic [4:0]      odrSh;
  logic [1:0]      pwrSh;
  logic [1:0]      frameAct;
  logic            decPend;
  logic [FC_W-1:0] flushCnt;

  logic inStandby, sensChg, frameApply, decApply, trig;

  assign inStandby  = (pwrMode_e'(curMode) == MODE_STANDBY) ||
                      (pwrMode_e'(curMode) == MODE_DEEP);
  assign sensChg    = primed && ({osrTCfg, osrPCfg, odrCfg, pwrCfg} !=
                                 {osrTSh, osrPSh, odrSh, pwrSh});
  assign frameApply = primed && inStandby && (frameSelCfg != frameAct);
  assign decApply   = primed && inStandby && (decSelCfg != decSelAct);
  assign trig       = sensChg || frameApply || (decApply && !decPend);

  assign flushBusy = (flushCnt != '0);

  always_comb begin
    stb.clr   = trig;
    stb.pair  = (frameAct == 2'b11);
    stb.rdReq = rdEn;
    stb.push  = wrEn && !flushBusy && !trig && !isFull && (frameAct != 2'b00);
    stb.pop   = rdEn && !flushBusy && !trig && !isEmpty;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primed    <= 1'b0;
      osrTSh    <= '0;
      osrPSh    <= '0;
      odrSh     <= '0;
      pwrSh     <= '0;
      frameAct  <= '0;
      decSelAct <= '0;
      decPend   <= 1'b0;
      flushCnt  <= '0;
    end else if (!primed) begin
      primed    <= 1'b1;
      osrTSh    <= osrTCfg;
      osrPSh    <= osrPCfg;
      odrSh     <= odrCfg;
      pwrSh     <= pwrCfg;
      frameAct  <= frameSelCfg;
      decSelAct <= decSelCfg;
    end else begin
      osrTSh <= osrTCfg;
      osrPSh <= osrPCfg;
      odrSh  <= odrCfg;
      pwrSh  <= pwrCfg;
      if (frameApply) frameAct  <= frameSelCfg;
      if (decApply)   decSelAct <= decSelCfg;
      if (inStandby)                     decPend <= 1'b0;
      else if (decSelCfg != decSelAct)   decPend <= 1'b1;
      if (trig)
        flushCnt <= (pwrMode_e'(curMode) == MODE_DEEP) ? FC_W'(FLUSH_DEEP_CYC)
                                                       : FC_W'(FLUSH_CYC);
      else if (flushBusy)
        flushCnt <= flushCnt - FC_W'(1);
    end
  end

endmodule

// File: rtl/sensor_frame_fifo.sv
module sensor_frame_fifo
  import sff_pkg::*;
#(
  parameter int SLOTS          = 32,
  parameter int CH_W           = 24,
  parameter int FLUSH_CYC      = 4,
  parameter int FLUSH_DEEP_CYC = 9,
  localparam int CNT_W = $clog2(SLOTS) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2*CH_W-1:0] wrData,
  input  logic              rdEn,
  output logic [2*CH_W-1:0] rdData,
  input  logic [2:0]        osrTCfg,
  input  logic [2:0]        osrPCfg,
  input  logic [4:0]        odrCfg,
  input  logic [1:0]        pwrCfg,
  input  logic [1:0]        frameSelCfg,
  input  logic [1:0]        decSelCfg,
  input  logic [2:0]        curMode,
  input  logic [CNT_W-1:0]  thrLvl,
  output logic [CNT_W-1:0]  frameCount,
  output logic              fullFlag,
  output logic              thrFlag,
  output logic              flushBusy,
  output logic [1:0]        decSelAct
);

  sffStrobe_t strobe;
  logic       isEmpty;

  sff_ctrl #(
    .FLUSH_CYC     (FLUSH_CYC),
    .FLUSH_DEEP_CYC(FLUSH_DEEP_CYC)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .rdEn       (rdEn),
    .osrTCfg    (osrTCfg),
    .osrPCfg    (osrPCfg),
    .odrCfg     (odrCfg),
    .pwrCfg     (pwrCfg),
    .frameSelCfg(frameSelCfg),
    .decSelCfg  (decSelCfg),
    .curMode    (curMode),
    .isFull     (fullFlag),
    .isEmpty    (isEmpty),
    .stb        (strobe),
    .flushBusy  (flushBusy),
    .decSelAct  (decSelAct)
  );

  sff_store #(
    .SLOTS(SLOTS),
    .CH_W (CH_W)
  ) i_store (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (strobe),
    .wrData    (wrData),
    .rdData    (rdData),
    .frameCount(frameCount),
    .isFull    (fullFlag),
    .isEmpty   (isEmpty)
  );

  assign thrFlag = (thrLvl != '0) && (frameCount >= thrLvl);

endmodule

// File: rtl/sff_chk.sv
module sff_chk #(
  parameter int SLOTS = 32,
  parameter int CH_W  = 24,
  localparam int CNT_W = $clog2(SLOTS) + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdEn,
  input logic              clrStb,
  input logic              pairMode,
  input logic [2*CH_W-1:0] rdData,
  input logic [CNT_W-1:0]  frameCount,
  input logic              fullFlag,
  input logic              flushBusy
);

  // R6
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrStb |=> (frameCount == '0) && flushBusy);

  // R8
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushBusy |=> (frameCount == '0));

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameCount <= (pairMode ? CNT_W'(SLOTS / 2) : CNT_W'(SLOTS)));

  // R4
  full_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fullFlag && !rdEn && !clrStb) |=> (frameCount == $past(frameCount)));

  // R4
  empty_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && frameCount == '0) |=> (rdData == '0));

  // R2
  full_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    fullFlag |-> (frameCount == (pairMode ? CNT_W'(SLOTS / 2) : CNT_W'(SLOTS))));

endmodule

bind sensor_frame_fifo sff_chk #(.SLOTS(SLOTS), .CH_W(CH_W)) i_sff_chk (
  .clk       (clk),
  .rstN      (rstN),
  .rdEn      (rdEn),
  .clrStb    (strobe.clr),
  .pairMode  (strobe.pair),
  .rdData    (rdData),
  .frameCount(frameCount),
  .fullFlag  (fullFlag),
  .flushBusy (flushBusy)
);

// File: tb/test_sensor_frame_fifo.sv
module test_sensor_frame_fifo;

  localparam int SLOTS = 32;
  localparam int CH_W  = 24;
  localparam int FN    = 4;
  localparam int FD    = 9;
  localparam int CNT_W = $clog2(SLOTS) + 1;
  localparam int DW    = 2 * CH_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic [2:0] osrTCfg = '0, osrPCfg = '0, curMode = '0;
  logic [4:0] odrCfg = '0;
  logic [1:0] pwrCfg = '0, frameSelCfg = 2'b01, decSelCfg = '0;
  logic [CNT_W-1:0] thrLvl = '0;
  logic [CNT_W-1:0] frameCount;
  logic fullFlag, thrFlag, flushBusy;
  logic [1:0] decSelAct;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;
  logic [DW-1:0] expQ[$];

  always #10 clk = ~clk;

  sensor_frame_fifo #(
    .SLOTS(SLOTS), .CH_W(CH_W), .FLUSH_CYC(FN), .FLUSH_DEEP_CYC(FD)
  ) i_sensor_frame_fifo (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .osrTCfg(osrTCfg), .osrPCfg(osrPCfg), .odrCfg(odrCfg),
    .pwrCfg(pwrCfg), .frameSelCfg(frameSelCfg), .decSelCfg(decSelCfg),
    .curMode(curMode), .thrLvl(thrLvl), .frameCount(frameCount),
    .fullFlag(fullFlag), .thrFlag(thrFlag), .flushBusy(flushBusy),
    .decSelAct(decSelAct)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // driver: one write, expected item queued when the model accepts it
  task automatic writeFrame(input logic [DW-1:0] d, input bit accept, input bit pair);
    wrEn = 1'b1; wrData = d;
    tick();
    wrEn = 1'b0;
    if (accept) expQ.push_back(pair ? d : {{CH_W{1'b0}}, d[CH_W-1:0]});
  endtask

  // monitor: one read, compared against the queue head (or zero)
  task automatic readFrame(input string req);
    logic [DW-1:0] e;
    rdEn = 1'b1;
    tick();
    rdEn = 1'b0;
    e = (expQ.size() != 0) ? expQ.pop_front() : '0;
    chk(req, rdData, e);
  endtask

  task automatic readZero(input string req);
    rdEn = 1'b1;
    tick();
    rdEn = 1'b0;
    chk(req, rdData, '0);
  endtask

  // after the trigger edge: busy for n cycles in total
  task automatic busyWindow(input string req, input int n);
    repeat (n - 1) tick();
    chk(req, flushBusy, 1'b1);
    tick();
    chk(req, flushBusy, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1 reset state
    chk("R1", frameCount, 0);
    chk("R1", {fullFlag, thrFlag, flushBusy}, 0);
    chk("R1", rdData, 0);
    chk("R1", decSelAct, 0);
    rstN = 1'b1;
    tick(); tick();
    chk("R1", flushBusy, 0);

    // R2 single-channel fill to 32
    for (int i = 0; i < SLOTS; i++) writeFrame(DW'(48'hAA0000_000100 + i), 1, 0);
    chk("R2", frameCount, SLOTS);
    chk("R2", fullFlag, 1);
    // R4 write to full dropped
    writeFrame(48'h0, 0, 0);
    chk("R4", frameCount, SLOTS);
    for (int i = 0; i < SLOTS; i++) readFrame("R2");
    chk("R2", frameCount, 0);
    chk("R2", fullFlag, 0);
    // R4 empty read
    readZero("R4");
    chk("R4", frameCount, 0);

    // R5 threshold
    thrLvl = 3;
    writeFrame(48'h11, 1, 0); writeFrame(48'h22, 1, 0);
    chk("R5", thrFlag, 0);
    writeFrame(48'h33, 1, 0);
    chk("R5", thrFlag, 1);
    thrLvl = 4; #1;
    chk("R5", thrFlag, 0);
    thrLvl = 2; #1;
    chk("R5", thrFlag, 1);
    thrLvl = 0; #1;
    chk("R5", thrFlag, 0);
    thrLvl = 1;
    @(negedge clk);

    // R6 sensor change flush, R8 blocking during busy
    odrCfg = 5'd7;
    tick();
    expQ.delete();
    chk("R6", frameCount, 0);
    chk("R6", thrFlag, 0);
    chk("R6", flushBusy, 1);
    writeFrame(48'h55, 0, 0);
    readZero("R8");
    chk("R8", frameCount, 0);
    busyWindow("R6", FN - 2);
    osrPCfg = 3'd2;
    tick();
    busyWindow("R6", FN);

    // R7 deep flush
    curMode = 3'd4;
    osrTCfg = 3'd5;
    tick();
    busyWindow("R7", FD);
    curMode = 3'd0;

    // R9 + R3 combined layout applied in standby
    frameSelCfg = 2'b11;
    tick();
    chk("R9", flushBusy, 1);
    busyWindow("R9", FN);
    for (int i = 0; i < SLOTS / 2; i++)
      writeFrame({24'h700000 + 24'(i), 24'h100000 + 24'(i)}, 1, 1);
    chk("R3", frameCount, SLOTS / 2);
    chk("R3", fullFlag, 1);
    writeFrame(48'hFFFFFF_FFFFFF, 0, 1);
    chk("R3", frameCount, SLOTS / 2);
    for (int i = 0; i < SLOTS / 2; i++) readFrame("R3");
    chk("R3", frameCount, 0);

    // R9 deferred frame select
    curMode = 3'd1;
    frameSelCfg = 2'b01;
    tick();
    chk("R9", flushBusy, 0);
    writeFrame(48'hABCDEF_123456, 1, 1);
    chk("R9", frameCount, 1);
    readFrame("R9");
    writeFrame(48'h0A0B0C_0D0E0F, 1, 1);
    curMode = 3'd0;
    tick();
    expQ.delete();
    chk("R9", flushBusy, 1);
    chk("R9", frameCount, 0);
    busyWindow("R9", FN);
    writeFrame(48'hABCDEF_123456, 1, 0);
    readFrame("R9");

    // R10 deferred decimation
    curMode = 3'd3;
    decSelCfg = 2'd2;
    tick(); tick();
    chk("R10", decSelAct, 0);
    chk("R10", flushBusy, 0);
    writeFrame(48'h77, 1, 0);
    curMode = 3'd0;
    tick();
    chk("R10", decSelAct, 2);
    chk("R10", flushBusy, 0);
    chk("R10", frameCount, 1);
    decSelCfg = 2'd1;
    tick();
    expQ.delete();
    chk("R10", decSelAct, 1);
    chk("R10", flushBusy, 1);
    busyWindow("R10", FN);

    // R11 disabled layout
    frameSelCfg = 2'b00;
    tick();
    busyWindow("R11", FN);
    writeFrame(48'h99, 0, 0);
    chk("R11", frameCount, 0);
    readZero("R11");

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule